// File: doc/BRIEF.md
# Bit-Serial Linear Expression Tree

This block evaluates the linear expression C + i·A for every integer position i in the range 0 to 2^N−1, all at once. It uses no multiplier. A binary tree of one-bit serial adders does the work. The coefficient A and the constant C enter as two's-complement words on two single-bit lines, least significant bit first. A start strobe marks bit 0 of each word. The block drives 2^N serial lines, one per screen column or row, and each line carries its own result word in the same bit order.

Each level of the tree splits every incoming stream into two children:

- One child is a registered copy of the parent.
- The other child is the parent plus A shifted left by the weight of that level. The shifted copy of A is a single delayed version of the input A, gated to zero in the low bit positions of the word.

All branches have the same register depth, so the result lines stay bit-aligned with one another. A forwarded strobe marks bit 0 of the result words. The block is parameterised by the word width W and the tree depth N, and holds 2^N−1 serial adders.

Top module: `bsl_tree`

## Requirements
- R1: Over the W cycles after an output strobe, line i carries (C + i·A) mod 2^W, least significant bit first, for every i from 0 to 2^N−1.
- R2: A word whose bit 0 is presented with `sow_in` high in one cycle appears with `sow_out` high and bit 0 on the lines exactly N cycles later, and later bits follow one per cycle.
- R3: All 2^N lines present bit j of their result words in the same cycle.
- R4: Negative values of A and C (bit W−1 set) are handled as two's complement, and sums that overflow wrap modulo 2^W with no indication.
- R5: A new word may start exactly W cycles after the previous one, with no gap. Its results do not depend on the previous word, because every carry is cleared at a word start.
- R6: Bits of A from an earlier word never reach the result of the next word. The shifted copy of A contributes zero in result bit positions below its shift amount.
- R7: After reset, `sow_out` is 0 and every line is 0 while the inputs are held at 0.
- R8: Values on `coef_a` and `const_c` during idle cycles between words have no effect on the next word's results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sow_in | input | 1 | High in the cycle that carries bit 0 of the input words |
| coef_a | input | 1 | Serial coefficient A, LSB first |
| const_c | input | 1 | Serial constant C, LSB first |
| sow_out | output | 1 | High in the cycle that carries bit 0 of the result words |
| lines | output | 2^N | Serial result lines; bit i carries C + i·A |

## Verification
The hardest case to reach from the ports is a word that starts in the cycle right after the previous word's sign bit. In that cycle, stale carries and the high bits of the previous A still sit in the adders and in the delay line. Back-to-back words are therefore driven with all-ones A and C followed by small or zero values. Any leaked carry or unmasked stale bit then shows up on the lines that add the largest shifts. Idle gaps are filled with random bits on both data inputs, so that carries are dirty at the next word start. Every line of every word is compared against C + i·A truncated to W bits, and the strobe latency is checked for each word.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

    // Width of a bit index that counts 0..w (w marks "outside a word").
    function automatic int unsigned bsl_idx_w(input int unsigned w);
        return $clog2(w + 1);
    endfunction

    // State of one serial adder: carry into the next bit, registered sum.
    typedef struct packed {
        logic carry;
        logic sum;
    } bsl_node_t;

endpackage

// File: rtl/bsl_framer.sv
module bsl_framer
    import bsl_pkg::*;
#(
    parameter int W = 16,
    parameter int N = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sow_in,
    input  logic                        coef_a,
    output logic [N-1:0][bsl_idx_w(W)-1:0] lvl_idx,
    output logic                        a_dly,
    output logic                        sow_out
);

    localparam int IW = bsl_idx_w(W);
    localparam int AD = (N > 1) ? N - 1 : 1;
    localparam logic [IW-1:0] W_L = IW'(W);

    typedef struct packed {
        logic [IW-1:0]         cnt;   // index of the next input bit
        logic [N:1][IW-1:0]    pipe;  // bit index seen by each register stage
        logic [AD-1:0]         adl;   // delay line for coefficient A
    } fr_t;

    fr_t fr_d, fr_q;
    logic [IW-1:0] idx_in;

    assign idx_in = sow_in ? '0 : fr_q.cnt;

    always_comb begin
        fr_d = fr_q;
        if (idx_in < W_L) begin
            fr_d.cnt = idx_in + IW'(1);
        end else begin
            fr_d.cnt = W_L;
        end
        fr_d.pipe[1] = idx_in;
        for (int k = 2; k <= N; k++) begin
            fr_d.pipe[k] = fr_q.pipe[k-1];
        end
        fr_d.adl = AD'({fr_q.adl, coef_a});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '{cnt: W_L, pipe: {N{W_L}}, adl: '0};
        end else begin
            fr_q <= fr_d;
        end
    end

    always_comb begin
        lvl_idx[0] = idx_in;
        for (int k = 1; k < N; k++) begin
            lvl_idx[k] = fr_q.pipe[k];
        end
    end

    // Every level needs A delayed by N-1 cycles in total.
    assign a_dly   = (N > 1) ? fr_q.adl[AD-1] : coef_a;
    assign sow_out = (fr_q.pipe[N] == '0);

    AST_SOW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        sow_in |-> (fr_q.cnt == W_L)); // R5

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.cnt <= W_L); // R2

endmodule

// File: rtl/bsl_add_node.sv
module bsl_add_node
    import bsl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic x,
    input  logic y,
    output logic sum
);

    bsl_node_t nd_d, nd_q;
    logic      cin;

    assign cin = start ? 1'b0 : nd_q.carry;

    always_comb begin
        nd_d.sum   = x ^ y ^ cin;
        nd_d.carry = (x & y) | (cin & (x ^ y));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nd_q <= '0;
        end else begin
            nd_q <= nd_d;
        end
    end

    assign sum = nd_q.sum;

    AST_CARRY_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (nd_q.carry == $past(x & y))); // R5

    AST_SUM_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (sum == $past(x ^ y))); // R5

endmodule

// File: rtl/bsl_level.sv
module bsl_level
    import bsl_pkg::*;
#(
    parameter int W = 16,
    parameter int N = 9,
    parameter int K = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [(2**K)-1:0]       par,
    input  logic [bsl_idx_w(W)-1:0] idx,
    input  logic                    a_dly,
    output logic [(2**(K+1))-1:0]   kid
);

    localparam int IW = bsl_idx_w(W);
    localparam int P  = 2**K;
    localparam int S  = N - 1 - K;   // shift of A at this level
    localparam logic [IW-1:0] S_L = IW'(S);

    typedef struct packed {
        logic [P-1:0] pass;
    } lv_t;

    lv_t  lv_d, lv_q;
    logic addend;
    logic start;
    logic [P-1:0] node_sum;

    assign start = (idx == '0);

    if (S == 0) begin : g_noshift
        assign addend = a_dly;
    end else begin : g_shift
        assign addend = (idx >= S_L) ? a_dly : 1'b0;
    end

    always_comb begin
        lv_d      = lv_q;
        lv_d.pass = par;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lv_q <= '0;
        end else begin
            lv_q <= lv_d;
        end
    end

    for (genvar p = 0; p < P; p++) begin : g_node
        bsl_add_node u_node (
            .clk   (clk),
            .rst_n (rst_n),
            .start (start),
            .x     (par[p]),
            .y     (addend),
            .sum   (node_sum[p])
        );
        assign kid[2*p]   = lv_q.pass[p];
        assign kid[2*p+1] = node_sum[p];

        if (S > 0) begin : g_chk
            AST_ZERO_ADDEND: assert property (@(posedge clk) disable iff (!rst_n)
                (idx < S_L) |=> (kid[2*p+1] == $past(par[p]))); // R6
        end
    end

endmodule

// File: rtl/bsl_tree.sv
module bsl_tree
    import bsl_pkg::*;
#(
    parameter int W = 16,
    parameter int N = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sow_in,
    input  logic              coef_a,
    input  logic              const_c,
    output logic              sow_out,
    output logic [(2**N)-1:0] lines
);

    localparam int IW = bsl_idx_w(W);
    localparam int L  = 2**N;

    // Streams of all levels, heap order: level k occupies [2^k-1 +: 2^k].
    logic [2*L-2:0]           stream;
    logic [N-1:0][IW-1:0]     lvl_idx;
    logic                     a_dly;

    assign stream[0] = const_c;

    bsl_framer #(.W(W), .N(N)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .sow_in  (sow_in),
        .coef_a  (coef_a),
        .lvl_idx (lvl_idx),
        .a_dly   (a_dly),
        .sow_out (sow_out)
    );

    for (genvar k = 0; k < N; k++) begin : g_lvl
        bsl_level #(.W(W), .N(N), .K(k)) u_level (
            .clk   (clk),
            .rst_n (rst_n),
            .par   (stream[(2**k)-1 +: 2**k]),
            .idx   (lvl_idx[k]),
            .a_dly (a_dly),
            .kid   (stream[(2**(k+1))-1 +: 2**(k+1)])
        );
    end

    assign lines = stream[L-1 +: L];

endmodule

// File: tb/tb_bsl_tree.sv
module tb_bsl_tree;

    localparam int W     = 8;
    localparam int N     = 3;
    localparam int LANES = 2**N;
    localparam int MAXW  = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sow_in = 1'b0;
    logic coef_a = 1'b0;
    logic const_c = 1'b0;
    logic sow_out;
    logic [LANES-1:0] lines;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    logic [W-1:0] exp_a [0:MAXW-1];
    logic [W-1:0] exp_c [0:MAXW-1];
    int           drv_cyc [0:MAXW-1];
    logic [W-1:0] got [0:MAXW-1][0:LANES-1];
    int           got_cyc [0:MAXW-1];
    int nsent = 0;
    int nrecv = 0;
    bit mon_on = 1'b0;
    int mon_bit = 0;

    bsl_tree #(.W(W), .N(N)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .sow_in  (sow_in),
        .coef_a  (coef_a),
        .const_c (const_c),
        .sow_out (sow_out),
        .lines   (lines)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Collect result words at the falling edge.
    always @(negedge clk) begin
        if (sow_out && nrecv < MAXW) begin
            mon_on  = 1'b1;
            mon_bit = 0;
            got_cyc[nrecv] = cyc;
        end
        if (mon_on) begin
            for (int l = 0; l < LANES; l++) got[nrecv][l][mon_bit] = lines[l];
            mon_bit++;
            if (mon_bit == W) begin
                mon_on = 1'b0;
                nrecv++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic send_word(input logic [W-1:0] a, input logic [W-1:0] c,
                             input int gap, input bit junk);
        for (int b = 0; b < W; b++) begin
            @(negedge clk);
            sow_in  = (b == 0);
            coef_a  = a[b];
            const_c = c[b];
            if (b == 0) begin
                exp_a[nsent]   = a;
                exp_c[nsent]   = c;
                drv_cyc[nsent] = cyc;
            end
        end
        nsent++;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            sow_in  = 1'b0;
            coef_a  = junk ? 1'($urandom) : 1'b0;
            const_c = junk ? 1'($urandom) : 1'b0;
        end
    endtask

    task automatic drain();
        @(negedge clk);
        sow_in = 1'b0; coef_a = 1'b0; const_c = 1'b0;
        repeat (N + W + 3) @(negedge clk);
    endtask

    task automatic check_words(input int first, input string vtag);
        for (int w = first; w < nsent; w++) begin
            chk(w < nrecv, "R2", "result word present", nrecv, w + 1);
            if (w < nrecv) begin
                chk(got_cyc[w] - drv_cyc[w] == N, "R2", "strobe latency",
                    got_cyc[w] - drv_cyc[w], N);
                for (int l = 0; l < LANES; l++) begin
                    logic [W-1:0] e;
                    e = W'(int'(exp_c[w]) + l * int'(exp_a[w]));
                    chk(got[w][l] == e, vtag, $sformatf("word %0d line %0d", w, l),
                        int'(got[w][l]), int'(e));
                end
            end
        end
    endtask

    // R7: idle state after reset
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N + 2; i++) begin
            @(negedge clk);
            chk(sow_out == 1'b0, "R7", "sow_out after reset", int'(sow_out), 0);
            chk(lines == '0, "R7", "lines after reset", int'(lines), 0);
        end
    endtask

    // R1: plain ramps and a constant
    task automatic t_ramp();
        int f = nsent;
        send_word(8'd1, 8'd0, 2, 1'b0);
        send_word(8'd3, 8'd5, 2, 1'b0);
        send_word(8'd0, 8'h5A, 2, 1'b0);
        send_word(8'd17, 8'd100, 2, 1'b0);
        drain();
        check_words(f, "R1");
    endtask

    // R4: negative operands and wrap-around
    task automatic t_wrap();
        int f = nsent;
        send_word(8'hFF, 8'h03, 1, 1'b0);
        send_word(8'h80, 8'h80, 1, 1'b0);
        send_word(8'h7F, 8'h7F, 1, 1'b0);
        send_word(8'hC0, 8'hF0, 1, 1'b0);
        drain();
        check_words(f, "R4");
    endtask

    // R5: back-to-back words after carry-heavy values
    task automatic t_b2b();
        int f = nsent;
        send_word(8'hFF, 8'hFF, 0, 1'b0);
        send_word(8'h01, 8'h00, 0, 1'b0);
        send_word(8'hFF, 8'hFF, 0, 1'b0);
        send_word(8'h00, 8'h01, 0, 1'b0);
        drain();
        check_words(f, "R5");
    endtask

    // R6: stale high bits of A must not leak into the next word
    task automatic t_stale_a();
        int f = nsent;
        send_word(8'hFF, 8'h00, 0, 1'b0);
        send_word(8'h00, 8'h00, 0, 1'b0);
        send_word(8'hE0, 8'h00, 0, 1'b0);
        send_word(8'h01, 8'h00, 0, 1'b0);
        drain();
        check_words(f, "R6");
    endtask

    // R8: random bits in idle gaps are ignored
    task automatic t_gap_junk();
        int f = nsent;
        send_word(8'h12, 8'h34, 3, 1'b1);
        send_word(8'h00, 8'h00, 3, 1'b1);
        send_word(8'h05, 8'hFE, 3, 1'b1);
        drain();
        check_words(f, "R8");
    endtask

    // R3: random words, all lines must line up with the strobe
    task automatic t_random();
        int f = nsent;
        for (int i = 0; i < 40; i++) begin
            send_word(W'($urandom), W'($urandom), int'($urandom % 4), 1'b1);
        end
        drain();
        check_words(f, "R3");
    endtask

    initial begin
        t_reset();
        t_ramp();
        t_wrap();
        t_b2b();
        t_stale_a();
        t_gap_junk();
        t_random();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule